// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. An external address is captured whenever either of two load strobes is high at a rising clock edge. One strobe comes from the processor side and the other from the memory-controller side. After the capture, the two least-significant address bits step internally, one position per cycle in which the advance input is high. The upper address bits keep the captured value for the whole burst.

A mode input chooses the burst ordering:

- **Linear:** a wrapping increment of the start offset.
- **Interleaved:** the start offset XORed with the burst position. The mode input is active-high for linear, so tying it low, the default, gives interleaved order.

Bursting is optional. A fresh address may be strobed in on every cycle, and each one appears on the output one edge later.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, addr_o, pos_o and last_o are all zero.
- R2: When strb_cpu_i is high at a rising edge, after that edge addr_o equals the sampled addr_i and pos_o is 0.
- R3: When strb_ctl_i is high at a rising edge, after that edge addr_o equals the sampled addr_i and pos_o is 0.
- R4: A load has priority over an advance. Both strobes high together, with or without adv_i, perform a single load of addr_i.
- R5: With neither strobe high, adv_i high steps pos_o by one, modulo 4. With adv_i also low, pos_o and addr_o hold their values.
- R6: With lin_mode_i = 1, addr_o[1:0] equals (start[1:0] + pos_o) mod 4, where start is the loaded address.
- R7: With lin_mode_i = 0 (the default tie-off), addr_o[1:0] equals start[1:0] XOR pos_o.
- R8: After four advances the address returns to the start address. Bits above bit 1 never change without a load, so there is no carry out of the low two bits.
- R9: last_o is 1 exactly when pos_o is 3, which marks the fourth word of a burst.
- R10: Strobing a new address on consecutive cycles presents each address on addr_o in the cycle after its strobe, with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | External address, sampled on a load |
| strb_cpu_i | input | 1 | Processor-side load strobe |
| strb_ctl_i | input | 1 | Controller-side load strobe |
| adv_i | input | 1 | Advance burst position |
| lin_mode_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_o | output | ADDR_W | Current word address |
| pos_o | output | CNT_W | Burst position, 0 to 3 |
| last_o | output | 1 | High at the last position of a burst |

## Verification
A wrong position count appears on addr_o[1:0] and pos_o one edge after the cycle that corrupted it, and it persists until the next load. A bad base register shows on the upper address bits at once, and it remains visible for the rest of the burst. The vector table steps full bursts in both orders, from start offsets 1, 2 and 3, so a swapped ordering, a missing wrap or a carry into bit 2 changes the very next sampled address. The directed tests add reset in the middle of a burst and a mode flip during a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } seq_act_e;
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
  import burst_seq_pkg::*;
(
  input  logic     strb_cpu_i,
  input  logic     strb_ctl_i,
  input  logic     adv_i,
  output seq_act_e act_o
);
  // load beats advance; either strobe alone is a full load
  always_comb begin
    if (strb_cpu_i || strb_ctl_i) act_o = ACT_LOAD;
    else if (adv_i)               act_o = ACT_STEP;
    else                          act_o = ACT_HOLD;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_act_e         act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (act_i)
        ACT_LOAD: cnt_q <= '0;
        ACT_STEP: cnt_q <= cnt_q + 1'b1;  // wraps, no carry out
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_MAX);

  assert_step_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_STEP) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
  assert_load_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_LOAD) |=> (cnt_o == '0));
endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int unsigned CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             lin_i,
  output logic [CNT_W-1:0] low_o
);
  logic [CNT_W-1:0] low_lin;
  logic [CNT_W-1:0] low_ilv;

  genvar g;
  generate
    for (g = 0; g < CNT_W; g++) begin : g_ilv
      assign low_ilv[g] = start_i[g] ^ cnt_i[g];
    end
  endgenerate

  assign low_lin = start_i + cnt_i;
  assign low_o   = lin_i ? low_lin : low_ilv;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strb_cpu_i,
  input  logic              strb_ctl_i,
  input  logic              adv_i,
  input  logic              lin_mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  pos_o,
  output logic              last_o
);
  localparam int unsigned HI_W = ADDR_W - CNT_W;

  seq_act_e          act;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  low;

  burst_load_ctrl i_load_ctrl (
    .strb_cpu_i (strb_cpu_i),
    .strb_ctl_i (strb_ctl_i),
    .adv_i      (adv_i),
    .act_o      (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               base_q <= '0;
    else if (act == ACT_LOAD)  base_q <= addr_i;
  end

  burst_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .cnt_o  (cnt),
    .last_o (last_o)
  );

  burst_order #(.CNT_W(CNT_W)) i_order (
    .start_i (base_q[CNT_W-1:0]),
    .cnt_i   (cnt),
    .lin_i   (lin_mode_i),
    .low_o   (low)
  );

  assign addr_o = {base_q[ADDR_W-1:CNT_W], low};
  assign pos_o  = cnt;

  assert_cpu_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_cpu_i |=> (addr_o[ADDR_W-1:CNT_W] == $past(addr_i[ADDR_W-1:CNT_W])) && (pos_o == '0));
  assert_ctl_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_ctl_i |=> (addr_o[ADDR_W-1:CNT_W] == $past(addr_i[ADDR_W-1:CNT_W])) && (pos_o == '0));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_i && !strb_ctl_i && !adv_i) |=> $stable(pos_o));
  assert_no_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_i && !strb_ctl_i) |=> $stable(addr_o[ADDR_W-1:CNT_W]));
  assert_last_pos_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (pos_o == {CNT_W{1'b1}}));
  assert_lin_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_mode_i |-> (CNT_W'(addr_o[CNT_W-1:0] - base_q[CNT_W-1:0]) == pos_o));
  assert_ilv_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lin_mode_i |-> ((addr_o[CNT_W-1:0] ^ base_q[CNT_W-1:0]) == pos_o));

  initial assert (HI_W >= 1) else $error("ADDR_W must exceed CNT_W");
endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 12;
  localparam int NV = 17;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strb_cpu_i = 1'b0, strb_ctl_i = 1'b0, adv_i = 1'b0, lin_mode_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [1:0]    pos_o;
  logic          last_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) i_burst_addr_seq (
    .clk_i, .rst_ni, .addr_i, .strb_cpu_i, .strb_ctl_i, .adv_i, .lin_mode_i,
    .addr_o, .pos_o, .last_o
  );

  // {cpu, ctl, adv, lin, addr, exp_addr, exp_pos}
  localparam logic [29:0] VEC [NV] = '{
    {4'b1001, 12'h5A6, 12'h5A6, 2'd0},  // R2 cpu load
    {4'b0011, 12'h000, 12'h5A7, 2'd1},  // R6 linear from 2
    {4'b0011, 12'h000, 12'h5A4, 2'd2},  // R6
    {4'b0011, 12'h000, 12'h5A5, 2'd3},  // R6 R9
    {4'b0011, 12'h000, 12'h5A6, 2'd0},  // R8 wrap
    {4'b0001, 12'h000, 12'h5A6, 2'd0},  // R5 hold
    {4'b0100, 12'h3F1, 12'h3F1, 2'd0},  // R3 ctl load
    {4'b0010, 12'h000, 12'h3F0, 2'd1},  // R7 interleaved from 1
    {4'b0010, 12'h000, 12'h3F3, 2'd2},  // R7
    {4'b0000, 12'h000, 12'h3F3, 2'd2},  // R5 hold mid-burst
    {4'b0010, 12'h000, 12'h3F2, 2'd3},  // R7 R9
    {4'b0010, 12'h000, 12'h3F1, 2'd0},  // R8 wrap
    {4'b1111, 12'h0AB, 12'h0AB, 2'd0},  // R4 both strobes + adv
    {4'b1011, 12'h123, 12'h123, 2'd0},  // R4 R10 back-to-back load
    {4'b0101, 12'h456, 12'h456, 2'd0},  // R10
    {4'b1001, 12'hFFF, 12'hFFF, 2'd0},  // R10
    {4'b0011, 12'h000, 12'hFFC, 2'd1}   // R8 no carry from 3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic t, input logic a, input logic l,
                       input logic [AW-1:0] ad);
    strb_cpu_i = c; strb_ctl_i = t; adv_i = a; lin_mode_i = l; addr_i = ad;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 addr", 32'(addr_o), 0);
    check("R1 pos", 32'(pos_o), 0);
    check("R1 last", 32'(last_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25:14]);
      check($sformatf("R2-table vec %0d addr", i), 32'(addr_o), 32'(VEC[i][13:2]));
      check($sformatf("R5-table vec %0d pos", i), 32'(pos_o), 32'(VEC[i][1:0]));
      check($sformatf("R9 vec %0d last", i), 32'(last_o), 32'(VEC[i][1:0] == 2'd3));
    end

    // R7 full interleaved burst from offset 2: 2,3,0,1
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h872);
    check("R7 start", 32'(addr_o), 32'h872);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R7 step1", 32'(addr_o), 32'h873);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R7 step2", 32'(addr_o), 32'h870);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R7 step3", 32'(addr_o), 32'h871);
    // mode flip mid-burst: pos 3 linear from 2 -> 1
    lin_mode_i = 1'b1; adv_i = 1'b0; #1;
    check("R6 flip", 32'(addr_o), 32'h871);
    check("R9 flip last", 32'(last_o), 1);
    // R4 advance with strobe ignored: addr reloads, pos stays 0
    drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h202);
    check("R4 reload pos", 32'(pos_o), 0);
    check("R4 reload addr", 32'(addr_o), 32'h202);

    // R1 reset mid-burst
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0);
    rst_ni = 1'b0; #1;
    check("R1 mid addr", 32'(addr_o), 0);
    check("R1 mid pos", 32'(pos_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0);
    check("R5 after reset", 32'(pos_o), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule